// File: doc/BRIEF.md
# Rename History Rollback Buffer

This block keeps an ordered log of destination-register renames for one hardware thread. The rename stage writes an entry each time it gives a destination operand a new physical register. The entry holds the instruction's sequence number, the architectural register, the new physical register, and the physical register that held that architectural register before. The log lets either side of that choice be released later.

When a squash request arrives with the sequence number of the last instruction that survives, the block walks the log from the youngest entry. For each younger entry it drives a restore write to the map table, putting back the earlier mapping, and hands the new physical register back to the free list. When a commit request arrives with the highest retired sequence number, the block walks from the oldest entry and returns each retired entry's earlier physical register to the free list. Each walk handles one entry per clock and holds `busy` high until it ends.

Top module: `rename_undo_log`

## Requirements
- R1: After reset the log is empty. `busy`, `restore_valid` and `free_valid` are low, and `alloc_ready` is high.
- R2: An allocation is taken on a clock edge where `alloc_valid` and `alloc_ready` are both high. It appends one entry at the youngest end, holding the sequence number, architectural register, new physical register and previous physical register.
- R3: When DEPTH entries are held, `alloc_ready` is low, and an offered allocation is not stored.
- R4: A squash walk goes from youngest to oldest at one entry per cycle, for as long as the entry's sequence number is strictly greater than the squash number. Each such entry is removed. In the same cycle it drives `restore_valid` with `restore_areg` = its architectural register and `restore_preg` = its previous register, and drives `free_valid` with `free_preg` = its new register.
- R5: A squash request while the log is empty causes no walk: `busy` stays low and no restore or free is issued.
- R6: A commit walk goes from oldest toward youngest at one entry per cycle, for as long as the entry's sequence number is less than or equal to the commit number. Each such entry is removed, and `free_valid` is driven with `free_preg` = its previous register and `restore_valid` low.
- R7: A commit request whose number is below the oldest entry's sequence number is ignored: `busy` stays low and nothing is freed.
- R8: No commit release happens in a cycle where `squash_valid` or `thread_squashing` is high. A squash and a commit raised together act as the squash alone. A commit request made while `thread_squashing` is high is dropped.
- R9: `busy` is high from the clock after a walk starts until the walk ends, and `alloc_ready` is low while `busy` is high.
- R10: A squash request during a commit walk ends the commit walk without releasing anything in that cycle. The squash walk then runs over the entries that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Rename offers a new log entry |
| alloc_seq | input | SEQ_W | Sequence number of the renaming instruction |
| alloc_areg | input | AREG_W | Architectural destination register |
| alloc_pnew | input | PREG_W | Newly allocated physical register |
| alloc_pold | input | PREG_W | Physical register previously mapped |
| alloc_ready | output | 1 | Entry can be accepted this cycle |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Last surviving sequence number |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Highest committed sequence number |
| thread_squashing | input | 1 | Thread is still squashing; commit release is held off |
| busy | output | 1 | A walk is in progress |
| restore_valid | output | 1 | Map-table restore write |
| restore_areg | output | AREG_W | Architectural register to restore |
| restore_preg | output | PREG_W | Physical register to write back into the map |
| free_valid | output | 1 | Return a physical register to the free list |
| free_preg | output | PREG_W | Physical register being returned |

## Verification
The bench builds the block with a depth of four, 8-bit sequence numbers, 5-bit architectural and 6-bit physical indices. The small depth means the full condition and the rejected fifth allocation are reached within a few cycles. With that depth, a single scenario can cover all of these: a squash that stops partway, a commit that stops at a younger entry, a commit preempted by a squash, and a squash of the last entries down to an empty log. The narrow sequence numbers keep the stale-commit and empty-squash cases easy to set up.

// File: rtl/rul_pkg.sv
package rul_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE   = 2'd0,
        WALK_SQUASH = 2'd1,
        WALK_COMMIT = 2'd2
    } walk_e;

    localparam int SEQ_CMP_W = 32;

    // Sequence numbers are assumed not to wrap while entries are live.
    function automatic logic seq_newer(input logic [SEQ_CMP_W-1:0] a,
                                       input logic [SEQ_CMP_W-1:0] b);
        return a > b;
    endfunction

endpackage

// File: rtl/rul_store.sv
module rul_store #(
    parameter int DEPTH = 8,
    parameter int EW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop_old,
    input  logic          pop_young,
    output logic [EW-1:0] old_entry,
    output logic [EW-1:0] young_entry,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] head_q, tail_q, young_idx;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] wrap_dec(input logic [PW-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    assign young_idx   = wrap_dec(tail_q);
    assign old_entry   = mem[head_q];
    assign young_entry = mem[young_idx];
    assign empty       = (cnt_q == '0);
    assign full        = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push) mem[tail_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push && !pop_young)      tail_q <= wrap_inc(tail_q);
            else if (pop_young && !push) tail_q <= young_idx;
            if (pop_old) head_q <= wrap_inc(head_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop_old) - CW'(pop_young);
        end
    end

    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    a_r2_count_grows: assert property (@(posedge clk) disable iff (rst)
        (push && !pop_old && !pop_young) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r4_single_pop_end: assert property (@(posedge clk) disable iff (rst)
        !(pop_old && pop_young));

endmodule

// File: rtl/rul_walker.sv
module rul_walker
    import rul_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             thread_squashing,
    input  logic             empty,
    input  logic [SEQ_W-1:0] young_seq,
    input  logic [SEQ_W-1:0] old_seq,
    output logic             pop_young,
    output logic             pop_old,
    output logic             busy
);
    walk_e            st_q, st_n;
    logic [SEQ_W-1:0] lim_q, lim_n;
    logic             commit_ok;

    assign commit_ok = commit_valid && !squash_valid && !thread_squashing;
    assign busy      = (st_q != WALK_IDLE);

    always_comb begin
        st_n      = st_q;
        lim_n     = lim_q;
        pop_young = 1'b0;
        pop_old   = 1'b0;
        unique case (st_q)
            WALK_IDLE: begin
                if (squash_valid) begin
                    if (!empty) begin
                        st_n  = WALK_SQUASH;
                        lim_n = squash_seq;
                    end
                end else if (commit_ok && !empty &&
                             !seq_newer(SEQ_CMP_W'(old_seq), SEQ_CMP_W'(commit_seq))) begin
                    st_n  = WALK_COMMIT;
                    lim_n = commit_seq;
                end
            end
            WALK_SQUASH: begin
                if (!empty && seq_newer(SEQ_CMP_W'(young_seq), SEQ_CMP_W'(lim_q)))
                    pop_young = 1'b1;
                else
                    st_n = WALK_IDLE;
                if (squash_valid) begin
                    st_n  = WALK_SQUASH;
                    lim_n = squash_seq;
                end
            end
            WALK_COMMIT: begin
                if (squash_valid) begin
                    st_n  = empty ? WALK_IDLE : WALK_SQUASH;
                    lim_n = squash_seq;
                end else if (thread_squashing) begin
                    st_n = WALK_IDLE;
                end else begin
                    if (!empty && !seq_newer(SEQ_CMP_W'(old_seq), SEQ_CMP_W'(lim_q)))
                        pop_old = 1'b1;
                    else
                        st_n = WALK_IDLE;
                    if (commit_valid && seq_newer(SEQ_CMP_W'(commit_seq), SEQ_CMP_W'(lim_q))) begin
                        st_n  = WALK_COMMIT;
                        lim_n = commit_seq;
                    end
                end
            end
            default: st_n = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WALK_IDLE;
            lim_q <= '0;
        end else begin
            st_q  <= st_n;
            lim_q <= lim_n;
        end
    end

    a_r5_empty_squash_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && squash_valid && empty) |=> !busy);

    a_r8_no_commit_in_squash: assert property (@(posedge clk) disable iff (rst)
        (squash_valid || thread_squashing) |-> !pop_old);

    a_r9_pops_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        (pop_old || pop_young) |-> busy);

endmodule

// File: rtl/rename_undo_log.sv
module rename_undo_log #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 16,
    parameter int AREG_W = 5,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [AREG_W-1:0] alloc_areg,
    input  logic [PREG_W-1:0] alloc_pnew,
    input  logic [PREG_W-1:0] alloc_pold,
    output logic              alloc_ready,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              thread_squashing,
    output logic              busy,
    output logic              restore_valid,
    output logic [AREG_W-1:0] restore_areg,
    output logic [PREG_W-1:0] restore_preg,
    output logic              free_valid,
    output logic [PREG_W-1:0] free_preg
);
    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [AREG_W-1:0] areg;
        logic [PREG_W-1:0] pnew;
        logic [PREG_W-1:0] pold;
    } log_ent_t;

    localparam int EW = $bits(log_ent_t);

    log_ent_t new_ent, old_ent, young_ent;
    logic     push, pop_old, pop_young, empty, full;

    assign new_ent     = '{seq: alloc_seq, areg: alloc_areg, pnew: alloc_pnew, pold: alloc_pold};
    assign alloc_ready = !busy && !full && !squash_valid;
    assign push        = alloc_valid && alloc_ready;

    rul_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_data  (new_ent),
        .pop_old    (pop_old),
        .pop_young  (pop_young),
        .old_entry  (old_ent),
        .young_entry(young_ent),
        .empty      (empty),
        .full       (full)
    );

    rul_walker #(.SEQ_W(SEQ_W)) u_walker (
        .clk             (clk),
        .rst             (rst),
        .squash_valid    (squash_valid),
        .squash_seq      (squash_seq),
        .commit_valid    (commit_valid),
        .commit_seq      (commit_seq),
        .thread_squashing(thread_squashing),
        .empty           (empty),
        .young_seq       (young_ent.seq),
        .old_seq         (old_ent.seq),
        .pop_young       (pop_young),
        .pop_old         (pop_old),
        .busy            (busy)
    );

    assign restore_valid = pop_young;
    assign restore_areg  = young_ent.areg;
    assign restore_preg  = young_ent.pold;
    assign free_valid    = pop_young || pop_old;
    assign free_preg     = pop_young ? young_ent.pnew : old_ent.pold;

    a_r4_restore_pairs_free: assert property (@(posedge clk) disable iff (rst)
        restore_valid |-> free_valid);

    a_r9_no_alloc_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !alloc_ready);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!busy && !free_valid && alloc_ready));

endmodule

// File: tb/rename_undo_log_bench.sv
module rename_undo_log_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 4;
    localparam int SEQ_W  = 8;
    localparam int AREG_W = 5;
    localparam int PREG_W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              alloc_valid = 0;
    logic [SEQ_W-1:0]  alloc_seq = '0;
    logic [AREG_W-1:0] alloc_areg = '0;
    logic [PREG_W-1:0] alloc_pnew = '0, alloc_pold = '0;
    logic              alloc_ready;
    logic              squash_valid = 0;
    logic [SEQ_W-1:0]  squash_seq = '0;
    logic              commit_valid = 0;
    logic [SEQ_W-1:0]  commit_seq = '0;
    logic              thread_squashing = 0;
    logic              busy, restore_valid, free_valid;
    logic [AREG_W-1:0] restore_areg;
    logic [PREG_W-1:0] restore_preg, free_preg;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_undo_log #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) u_rename_undo_log (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_areg(alloc_areg),
        .alloc_pnew(alloc_pnew), .alloc_pold(alloc_pold), .alloc_ready(alloc_ready),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .thread_squashing(thread_squashing), .busy(busy),
        .restore_valid(restore_valid), .restore_areg(restore_areg), .restore_preg(restore_preg),
        .free_valid(free_valid), .free_preg(free_preg)
    );

    typedef struct { int seq; int areg; int pnew; int pold; } ment_t;
    ment_t mq[$];

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic do_alloc(input int seq, input int areg, input int pnew, input int pold, input bit expect_ok);
        chk(expect_ok ? "R2" : "R3", "alloc_ready", int'(alloc_ready), int'(expect_ok));
        alloc_valid = 1; alloc_seq = SEQ_W'(seq); alloc_areg = AREG_W'(areg);
        alloc_pnew = PREG_W'(pnew); alloc_pold = PREG_W'(pold);
        @(posedge clk); @(negedge clk);
        alloc_valid = 0;
        #1;
        if (expect_ok) mq.push_back('{seq, areg, pnew, pold});
    endtask

    task automatic walk_squash(input int lim, input string req);
        while (mq.size() > 0 && mq[$].seq > lim) begin
            chk(req, "restore_valid", int'(restore_valid), 1);
            chk(req, "restore_areg", int'(restore_areg), mq[$].areg);
            chk(req, "restore_preg", int'(restore_preg), mq[$].pold);
            chk(req, "free_preg(new)", int'(free_preg), mq[$].pnew);
            chk("R9", "busy in squash walk", int'(busy), 1);
            chk("R9", "alloc_ready in walk", int'(alloc_ready), 0);
            void'(mq.pop_back());
            step();
        end
        chk(req, "restore_valid at walk end", int'(restore_valid), 0);
        chk(req, "free_valid at walk end", int'(free_valid), 0);
        step();
        chk("R9", "busy after squash walk", int'(busy), 0);
    endtask

    task automatic walk_commit(input int lim);
        while (mq.size() > 0 && mq[0].seq <= lim) begin
            chk("R6", "free_valid", int'(free_valid), 1);
            chk("R6", "restore_valid", int'(restore_valid), 0);
            chk("R6", "free_preg(prev)", int'(free_preg), mq[0].pold);
            chk("R9", "busy in commit walk", int'(busy), 1);
            void'(mq.pop_front());
            step();
        end
        chk("R6", "free_valid at walk end", int'(free_valid), 0);
        step();
        chk("R9", "busy after commit walk", int'(busy), 0);
    endtask

    task automatic start_squash(input int lim);
        squash_valid = 1; squash_seq = SEQ_W'(lim);
        @(posedge clk); @(negedge clk);
        squash_valid = 0;
        #1;
    endtask

    task automatic start_commit(input int lim);
        commit_valid = 1; commit_seq = SEQ_W'(lim);
        @(posedge clk); @(negedge clk);
        commit_valid = 0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "restore_valid", int'(restore_valid), 0);
        chk("R1", "free_valid", int'(free_valid), 0);
        chk("R1", "alloc_ready", int'(alloc_ready), 1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) do_alloc(10 + i, 1 + i, 20 + i, 40 + i, 1'b1);
        do_alloc(14, 9, 29, 49, 1'b0);   // R3: rejected, must never appear in a walk
    endtask

    task automatic t_partial_squash();
        start_squash(11);
        walk_squash(11, "R4");
    endtask

    task automatic t_stale_commit();
        start_commit(5);
        chk("R7", "busy after stale commit", int'(busy), 0);
        chk("R7", "free_valid after stale commit", int'(free_valid), 0);
        step();
        chk("R7", "still idle", int'(busy), 0);
    endtask

    task automatic t_commit_one();
        start_commit(10);
        walk_commit(10);
    endtask

    task automatic t_suppress();
        do_alloc(20, 6, 30, 50, 1'b1);
        do_alloc(21, 7, 31, 51, 1'b1);
        do_alloc(22, 8, 32, 52, 1'b1);
        thread_squashing = 1;
        start_commit(30);
        thread_squashing = 0;
        #1;
        chk("R8", "busy after commit while squashing", int'(busy), 0);
        chk("R8", "free_valid after commit while squashing", int'(free_valid), 0);
        // squash and commit together: only the squash acts
        commit_valid = 1; commit_seq = SEQ_W'(30);
        start_squash(21);
        commit_valid = 0;
        #1;
        walk_squash(21, "R8");
    endtask

    task automatic t_preempt();
        start_commit(30);
        chk("R10", "first commit free", int'(free_preg), mq[0].pold);
        chk("R10", "first commit valid", int'(free_valid), 1);
        void'(mq.pop_front());
        step();
        squash_valid = 1; squash_seq = SEQ_W'(19);
        #1;
        chk("R10", "commit free held in squash cycle", int'(free_valid), 0);
        chk("R8", "no restore before squash walk", int'(restore_valid), 0);
        @(posedge clk); @(negedge clk);
        squash_valid = 0;
        #1;
        walk_squash(19, "R10");
    endtask

    task automatic t_empty();
        start_squash(0);
        chk("R5", "busy after empty squash", int'(busy), 0);
        chk("R5", "restore_valid after empty squash", int'(restore_valid), 0);
        chk("R5", "free_valid after empty squash", int'(free_valid), 0);
        start_commit(200);
        chk("R7", "commit on empty ignored", int'(busy), 0);
        do_alloc(60, 3, 13, 33, 1'b1);
        start_commit(60);
        walk_commit(60);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_fill();
        t_partial_squash();
        t_stale_commit();
        t_commit_one();
        t_suppress();
        t_preempt();
        t_empty();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule